// File: doc/BRIEF.md
# Pin Input Debounce Filter

This block conditions one asynchronous pad input before it reaches the pin status readout and the interrupt detector. The pad level is brought into the core clock domain by a two-stage synchronizer. A filter then decides when the conditioned output may move to the synchronized level. Time is measured in pulses of a slow real-time tick, `slowTick`, which is high for one core clock per tick. A prescaler groups these ticks into units of 2, 8, 512 or 2048. A 4-bit count sets how many units a new level has to persist before the output accepts it.

A 2-bit mode field sets which transitions are filtered. Bit 0 set means rising transitions are filtered. Bit 1 set means falling transitions are filtered. The value 00 therefore turns the filter off, and 11 removes glitches of both polarities. Mode 01 lets low-going pulses through at once and delays only rising edges. Mode 10 lets high-going pulses through at once and delays only falling edges. A count of zero counts as an unconfigured filter, and the output then follows the synchronized input.

Top module: `pin_input_filter`

## Requirements
- R1: With `dbMode` = 00 the output copies the pad with a latency of exactly three clock edges: two synchronizer stages and the output register.
- R2: `dbMode` bit 0 enables filtering of rising (0→1) transitions and bit 1 enables filtering of falling (1→0) transitions. An unfiltered transition reaches the output with the same three-edge latency as in R1.
- R3: A filtered transition reaches the output on the clock edge that samples the N-th `slowTick` pulse seen while the synchronized input differs from the output, where N = `dbCount` × unit. The unit is selected by `dbUnitSel` (bit 1 large, bit 0 unit): 00 = 2, 01 = 8, 10 = 512, 11 = 2048 ticks.
- R4: The output only ever moves to the level of the synchronized input, never away from it.
- R5: With `dbMode` = 01 a falling pad transition reaches the output after three edges, and a rising one waits for the full window.
- R6: With `dbMode` = 10 a rising pad transition reaches the output after three edges, and a falling one waits for the full window.
- R7: With `dbCount` = 0 the filter is bypassed in every mode, and the output follows the synchronized input after one edge.
- R8: If the synchronized input returns to the output level before the window expires, the accumulated time is discarded, and a later attempt needs a full window again.
- R9: Changing `dbCount`, `dbUnitSel` or `dbMode` while the input is settled does not change the output level.
- R10: While `rstN` is low the output is 0. For the first three edges after release the filter is bypassed, so the output takes the pad level on the third edge whatever the configuration.
- R11: While filtering is active in the direction of a pending transition, the output cannot change on an edge that does not sample a `slowTick` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-cycle pulse per slow real-time tick |
| padIn | input | 1 | Asynchronous pad level |
| dbCount | input | CNT_W (4) | Window length in units; 0 = unconfigured (bypass) |
| dbUnitSel | input | 2 | Unit select {large, unit}: 2/8/512/2048 ticks |
| dbMode | input | 2 | Bit 0 filters rising, bit 1 filters falling transitions |
| filtOut | output | 1 | Filtered pin level |

## Verification
The hardest case to reach is a window that expires exactly on its last tick while the input is still changing. From the ports alone it is hard to tell whether a flip came on tick N, on tick N+1, or after a restart the design failed to make. The bench therefore stops the tick, toggles the pad, and lets the synchronizer settle. It then hands out ticks one at a time and checks that the output holds after N−1 ticks and moves on the N-th, for each unit. Random segments mix pulse widths around the window with random tick patterns. A tick-counting model runs in lockstep and flags any off-by-one or missed restart.

// File: rtl/pif_pkg.sv
package pif_pkg;
  localparam int FILT_RISE_BIT = 0;
  localparam int FILT_FALL_BIT = 1;

  typedef struct packed {
    logic clrWin;
    logic stepPre;
    logic stepDbc;
    logic loadOut;
  } pifStrobe_t;
endpackage

// File: rtl/pif_datapath.sv
module pif_datapath
  import pif_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int PRE_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             padIn,
  input  pifStrobe_t       strobe,
  output logic             syncLevel,
  output logic [PRE_W-1:0] preCnt,
  output logic [CNT_W-1:0] dbcCnt,
  output logic             filtOut
);
  logic [1:0] syncPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[0], padIn};
  end
  assign syncLevel = syncPipe[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) filtOut <= 1'b0;
    else if (strobe.loadOut) filtOut <= syncLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      dbcCnt <= '0;
    end else if (strobe.clrWin || strobe.loadOut) begin
      preCnt <= '0;
      dbcCnt <= '0;
    end else if (strobe.stepDbc) begin
      preCnt <= '0;
      dbcCnt <= dbcCnt + 1'b1;
    end else if (strobe.stepPre) begin
      preCnt <= preCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pif_ctrl.sv
module pif_ctrl
  import pif_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int PRE_W  = 11,
  parameter int UNIT_A = 2,
  parameter int UNIT_B = 8,
  parameter int UNIT_C = 512,
  parameter int UNIT_D = 2048
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slowTick,
  input  logic             syncLevel,
  input  logic             filtOut,
  input  logic [PRE_W-1:0] preCnt,
  input  logic [CNT_W-1:0] dbcCnt,
  input  logic [CNT_W-1:0] dbCount,
  input  logic [1:0]       dbUnitSel,
  input  logic [1:0]       dbMode,
  output pifStrobe_t       strobe
);
  localparam int PW1 = PRE_W + 1;
  localparam int CW1 = CNT_W + 1;

  logic [1:0]     primeCnt;
  logic           primed;
  logic [PW1-1:0] unitTicks;
  logic           mismatch, goingHigh, filterOn, preLast, dbcLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primeCnt <= '0;
    else if (primeCnt != 2'd3) primeCnt <= primeCnt + 2'd1;
  end
  assign primed = (primeCnt == 2'd3);

  always_comb begin
    case (dbUnitSel)
      2'b00:   unitTicks = PW1'(UNIT_A);
      2'b01:   unitTicks = PW1'(UNIT_B);
      2'b10:   unitTicks = PW1'(UNIT_C);
      default: unitTicks = PW1'(UNIT_D);
    endcase
  end

  assign mismatch  = syncLevel ^ filtOut;
  assign goingHigh = syncLevel & ~filtOut;
  assign filterOn  = primed && (dbCount != '0) &&
                     (goingHigh ? dbMode[FILT_RISE_BIT] : dbMode[FILT_FALL_BIT]);
  assign preLast   = ({1'b0, preCnt} + PW1'(1)) >= unitTicks;
  assign dbcLast   = ({1'b0, dbcCnt} + CW1'(1)) >= {1'b0, dbCount};

  always_comb begin
    strobe = '0;
    if (!mismatch) begin
      strobe.clrWin = 1'b1;
    end else if (!filterOn) begin
      strobe.loadOut = 1'b1;
    end else if (slowTick) begin
      if (!preLast)     strobe.stepPre = 1'b1;
      else if (dbcLast) strobe.loadOut = 1'b1;
      else              strobe.stepDbc = 1'b1;
    end
  end
endmodule

// File: rtl/pin_input_filter.sv
module pin_input_filter
  import pif_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int UNIT_A = 2,
  parameter int UNIT_B = 8,
  parameter int UNIT_C = 512,
  parameter int UNIT_D = 2048
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slowTick,
  input  logic             padIn,
  input  logic [CNT_W-1:0] dbCount,
  input  logic [1:0]       dbUnitSel,
  input  logic [1:0]       dbMode,
  output logic             filtOut
);
  localparam int MAX_AB   = (UNIT_A > UNIT_B) ? UNIT_A : UNIT_B;
  localparam int MAX_CD   = (UNIT_C > UNIT_D) ? UNIT_C : UNIT_D;
  localparam int UNIT_MAX = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int PRE_W    = (UNIT_MAX > 2) ? $clog2(UNIT_MAX) : 1;

  pifStrobe_t       strobe;
  logic             syncLevel;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] dbcCnt;

  pif_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .padIn(padIn), .strobe(strobe),
    .syncLevel(syncLevel), .preCnt(preCnt), .dbcCnt(dbcCnt), .filtOut(filtOut)
  );

  pif_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .UNIT_A(UNIT_A), .UNIT_B(UNIT_B),
             .UNIT_C(UNIT_C), .UNIT_D(UNIT_D)) u_ctl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .syncLevel(syncLevel),
    .filtOut(filtOut), .preCnt(preCnt), .dbcCnt(dbcCnt), .dbCount(dbCount),
    .dbUnitSel(dbUnitSel), .dbMode(dbMode), .strobe(strobe)
  );
endmodule

// File: rtl/pif_checker.sv
module pif_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             slowTick,
  input logic             syncLevel,
  input logic             filtOut,
  input logic [CNT_W-1:0] dbCount,
  input logic [1:0]       dbMode
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_bypass_follow: assert property (@(posedge clk) disable iff (!rstN)
    (dbMode == 2'b00 && syncLevel != filtOut) |=> (filtOut == $past(syncLevel)));

  a_r4_out_toward_input: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && filtOut != $past(filtOut)) |-> (filtOut == $past(syncLevel)));

  a_r5_low_pulse_passes: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && dbMode == 2'b01 && dbCount != '0 && !syncLevel && filtOut) |=> !filtOut);

  a_r6_high_pulse_passes: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && dbMode == 2'b10 && dbCount != '0 && syncLevel && !filtOut) |=> filtOut);

  a_r7_zero_count_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && dbCount == '0 && syncLevel != filtOut) |=> (filtOut == $past(syncLevel)));

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && dbMode == 2'b11 && dbCount != '0 && !slowTick) |=> $stable(filtOut));
endmodule

bind pin_input_filter pif_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .slowTick(slowTick), .syncLevel(syncLevel),
  .filtOut(filtOut), .dbCount(dbCount), .dbMode(dbMode)
);

// File: tb/sim_pin_input_filter.sv
`timescale 1ns/1ps
module sim_pin_input_filter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slowTick = 1'b0;
  logic       padIn = 1'b0;
  logic [3:0] dbCount = 4'd0;
  logic [1:0] dbUnitSel = 2'd0;
  logic [1:0] dbMode = 2'd0;
  logic       filtOut;

  int    nChecks = 0;
  int    nFail = 0;
  bit    cmpOn = 1'b0;
  string curTag = "R2 random";

  always #10 clk = ~clk;

  pin_input_filter u0 (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .padIn(padIn),
    .dbCount(dbCount), .dbUnitSel(dbUnitSel), .dbMode(dbMode), .filtOut(filtOut)
  );

  function automatic int unitOf(input logic [1:0] sel);
    case (sel)
      2'b00:   return 2;
      2'b01:   return 8;
      2'b10:   return 512;
      default: return 2048;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: filtOut=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // tick-counting reference model
  logic m1, m2, mOut;
  int   acc, mEdge, need;
  bit   filtOn;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= 0; m2 <= 0; mOut <= 0; acc <= 0; mEdge <= 0;
    end else begin
      need   = int'(dbCount) * unitOf(dbUnitSel);
      filtOn = (mEdge >= 3) && (dbCount != 0) && (m2 ? dbMode[0] : dbMode[1]);
      if (m2 != mOut) begin
        if (!filtOn) begin mOut <= m2; acc <= 0; end
        else if (slowTick) begin
          if (acc + 1 >= need) begin mOut <= m2; acc <= 0; end
          else acc <= acc + 1;
        end
      end else acc <= 0;
      m1 <= padIn; m2 <= m1;
      if (mEdge < 3) mEdge <= mEdge + 1;
    end
  end

  always @(negedge clk) if (rstN && cmpOn) check(curTag, filtOut, mOut);

  task automatic cyc(input logic pad, input logic tk);
    @(posedge clk); #2;
    padIn = pad; slowTick = tk;
  endtask

  task automatic settleBypass(input logic p);
    dbMode = 2'b00;
    repeat (5) cyc(p, 0);
  endtask

  task automatic windowTest(input logic [1:0] sel, input logic [3:0] cnt, input string tag);
    int n;
    logic p;
    n = int'(cnt) * unitOf(sel);
    p = filtOut;
    dbUnitSel = sel; dbCount = cnt; dbMode = 2'b11;
    cyc(~p, 0);
    repeat (4) cyc(~p, 0);
    check({tag, " R11 no tick"}, filtOut, p);
    repeat (n - 1) cyc(~p, 1);
    cyc(~p, 0);
    check({tag, " R3 before N"}, filtOut, p);
    cyc(~p, 1);
    cyc(~p, 0);
    check({tag, " R3 at N"}, filtOut, ~p);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(150000 * 20);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    // R10 reset behaviour
    padIn = 1'b1; dbMode = 2'b11; dbCount = 4'd15; dbUnitSel = 2'b11;
    repeat (3) @(posedge clk);
    #5 check("R10 reset", filtOut, 1'b0);
    @(posedge clk); #2 rstN = 1'b1;
    cyc(1, 0); cyc(1, 0);
    check("R10 before third edge", filtOut, 1'b0);
    cyc(1, 0);
    check("R10 third edge", filtOut, 1'b1);
    cmpOn = 1'b1;
    curTag = "directed";

    // R1 bypass latency
    settleBypass(1);
    cyc(0, 0); cyc(0, 0); cyc(0, 0);
    check("R1 after two edges", filtOut, 1'b1);
    cyc(0, 0);
    check("R1 third edge", filtOut, 1'b0);

    // R3 window per unit
    dbCount = 4'd5;
    windowTest(2'b00, 4'd5, "u00");
    windowTest(2'b01, 4'd5, "u01");
    windowTest(2'b10, 4'd2, "u10");
    windowTest(2'b11, 4'd1, "u11");

    // R8 restart
    settleBypass(0);
    dbUnitSel = 2'b00; dbCount = 4'd4; dbMode = 2'b11;
    repeat (3) cyc(1, 0);
    repeat (6) cyc(1, 1);
    repeat (4) cyc(0, 0);
    check("R8 aborted attempt", filtOut, 1'b0);
    repeat (3) cyc(1, 0);
    repeat (7) cyc(1, 1);
    cyc(1, 0);
    check("R8 restart needs full window", filtOut, 1'b0);
    cyc(1, 1); cyc(1, 0);
    check("R8 full window", filtOut, 1'b1);

    // R5 mode 01
    settleBypass(1);
    dbMode = 2'b01; dbCount = 4'd15; dbUnitSel = 2'b01;
    cyc(0, 1); cyc(0, 1); cyc(0, 1); cyc(0, 1);
    check("R5 falling passes", filtOut, 1'b0);
    repeat (12) cyc(1, 1);
    check("R5 rising held", filtOut, 1'b0);

    // R6 mode 10
    settleBypass(0);
    dbMode = 2'b10;
    cyc(1, 1); cyc(1, 1); cyc(1, 1); cyc(1, 1);
    check("R6 rising passes", filtOut, 1'b1);
    repeat (12) cyc(0, 1);
    check("R6 falling held", filtOut, 1'b1);

    // R7 count zero
    settleBypass(1);
    dbMode = 2'b11; dbCount = 4'd0;
    cyc(0, 0); cyc(0, 0); cyc(0, 0); cyc(0, 0);
    check("R7 zero count follows", filtOut, 1'b0);

    // R9 config change while settled
    dbCount = 4'd9; dbUnitSel = 2'b10; dbMode = 2'b01;
    repeat (3) cyc(0, 1);
    check("R9 config change", filtOut, 1'b0);
    dbCount = 4'd1; dbUnitSel = 2'b00; dbMode = 2'b10;
    repeat (3) cyc(0, 1);
    check("R9 second change", filtOut, 1'b0);

    // random segments, checked by lockstep model (R2 R3 R4 R8 R9 R11)
    curTag = "R2 random";
    void'($urandom(32'd1234));
    for (int seg = 0; seg < 30; seg++) begin
      logic p;
      int lim;
      p = padIn;
      repeat (130) cyc(p, 1);
      dbMode = 2'($urandom % 4);
      dbCount = 4'($urandom % 16);
      dbUnitSel = 2'($urandom % 2);
      if ($urandom % 8 == 0) begin dbUnitSel = 2'b10; dbCount = 4'd0; end
      lim = int'(dbCount) * unitOf(dbUnitSel) * 3 / 2 + 4;
      if (lim > 200) lim = 200;
      for (int run = 0; run < 20; run++) begin
        int len;
        p = ~p;
        len = 1 + int'($urandom % lim);
        for (int k = 0; k < len; k++) cyc(p, 1'($urandom % 2));
      end
    end
    repeat (4) cyc(padIn, 0);
    finishRun();
  end
endmodule